// File: doc/BRIEF.md
# Circular Trace Capture Buffer

This block collects already-packed trace words into an on-chip ring of storage. While capture is enabled, every valid word is first latched in a one-word formatter stage. On the next clock it is written to the slot named by the write pointer, and the pointer then advances, wrapping at the ring depth. A sticky flag records that the ring has wrapped at least once, so any older content has been overwritten.

A trace word can carry a trigger mark. Storing a marked word sets the triggered flag. From then on, each stored word counts a post-trigger counter down. When it runs out, the block clears its own capture enable and raises acquisition complete. The buffer therefore holds a window around the trigger event.

Software reaches the buffer through a small register port with an address, write data, a write strobe and a read strobe. Read data is combinational on the address. Reading the data window returns the word at the read pointer. A read strobe on that window then moves the read pointer one slot forward, so the whole trace can be drained with back-to-back reads.

Top module: `trace_ring_buf`

## Requirements
- R1: After reset, control reads 0, status reads 0x8 (only the formatter-empty bit 3 set), and the write pointer, read pointer and trigger counter all read 0.
- R2: Address 0 returns a fixed identification constant, address 1 returns the ring depth and address 2 returns the trace word width. Writes to these three addresses change nothing.
- R3: While control bit 0 (enable) is set, each word offered with `trc_valid` is written at the write pointer (address 6) one cycle after it is accepted, and the pointer advances by one. A software write to address 6 loads the pointer.
- R4: The write pointer wraps from depth-1 to 0. Status bit 0 (full) becomes set on that wrap and stays set until capture is re-enabled.
- R5: Storing a word with `trc_trig` set raises status bit 1 (triggered). With the trigger counter (address 7) at N>0, exactly N further words are stored. After that, control bit 0 clears, status bit 2 (complete) sets, and later words are not stored.
- R6: With the trigger counter at 0, acquisition completes on the trigger word itself, and no later word is stored.
- R7: Address 4 reads the word at the read pointer (address 5). A read strobe on address 4 advances the read pointer by one, modulo the depth. A write to address 5 loads the read pointer.
- R8: While control bit 0 is clear, offered words are not stored and the write pointer does not move. Writing 0 to control stops an ongoing capture.
- R9: Writing control with bit 0 set while capture is disabled clears full, triggered and complete.
- R10: Control bit 1 selects demultiplexed port mode. It reads back at address 8 and drives `demux_mode` from the cycle after the write.
- R11: Status bit 3 (formatter empty) reads 0 in the cycle after a word is accepted and 1 when no word is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| trc_valid | input | 1 | A packed trace word is offered this cycle |
| trc_word | input | WIDTH | Packed trace word |
| trc_trig | input | 1 | The offered word is the trigger point |
| cfg_addr | input | 4 | Register address 0..8 |
| cfg_wdata | input | 32 | Register write data |
| cfg_wr | input | 1 | Register write strobe |
| cfg_rd | input | 1 | Register read strobe (side effect only on address 4) |
| cfg_rdata | output | 32 | Register read data for `cfg_addr`, combinational |
| demux_mode | output | 1 | Demultiplexed port mode selected |

## Verification
The assertions check the properties that hold cycle by cycle:
- the full flag stays set unless capture restarts;
- the write pointer moves by at most one slot per cycle unless software loads it;
- a set complete flag always comes with the enable cleared;
- an accepted word always clears formatter-empty;
- a read strobe on the data window steps the read pointer;
- the mode output follows control writes.

Only the bench scenarios can show the counting behaviour: the exact number of words kept after a trigger, wrap-around content and the order of read-out, and that words offered after a stop or after completion leave the ring untouched.

// File: rtl/trb_pkg.sv
package trb_pkg;

    typedef enum logic [3:0] {
        A_IDENT  = 4'd0,
        A_DEPTH  = 4'd1,
        A_WIDTH  = 4'd2,
        A_STATUS = 4'd3,
        A_DATA   = 4'd4,
        A_RDPTR  = 4'd5,
        A_WRPTR  = 4'd6,
        A_TCOUNT = 4'd7,
        A_CTRL   = 4'd8
    } reg_addr_e;

    localparam int ST_FULL  = 0;
    localparam int ST_TRIG  = 1;
    localparam int ST_DONE  = 2;
    localparam int ST_EMPTY = 3;

    localparam int CT_EN    = 0;
    localparam int CT_DEMUX = 1;

endpackage

// File: rtl/trb_ring_ram.sv
module trb_ring_ram #(
    parameter int DEPTH = 16,
    parameter int WIDTH = 24,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic [AW-1:0]    raddr,
    output logic [WIDTH-1:0] rdata
);

    logic [WIDTH-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/trb_capture.sv
module trb_capture #(
    parameter int DEPTH = 16,
    parameter int WIDTH = 24,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cap_en,
    input  logic             restart,
    input  logic             in_valid,
    input  logic [WIDTH-1:0] in_word,
    input  logic             in_trig,
    input  logic             wp_ld,
    input  logic             cnt_ld,
    input  logic [31:0]      ld_val,
    output logic             ram_we,
    output logic [AW-1:0]    ram_waddr,
    output logic [WIDTH-1:0] ram_wdata,
    output logic [AW-1:0]    wp,
    output logic             full,
    output logic             triggered,
    output logic             acq_done,
    output logic             fmt_empty,
    output logic [31:0]      tcnt,
    output logic             done_pulse
);

    typedef struct packed {
        logic             pend;
        logic [WIDTH-1:0] pend_word;
        logic             pend_trig;
        logic [AW-1:0]    wp;
        logic             full;
        logic             trig;
        logic             acq;
        logic [31:0]      cnt;
    } cap_state_t;

    cap_state_t st_d, st_q;

    function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    logic store;
    logic trig_now;
    logic finish;

    always_comb begin
        st_d     = st_q;
        store    = st_q.pend && !st_q.acq;
        trig_now = st_q.trig || st_q.pend_trig;
        finish   = 1'b0;

        // formatter stage: one word in flight
        st_d.pend      = in_valid && cap_en;
        st_d.pend_word = in_word;
        st_d.pend_trig = in_trig;

        if (store) begin
            st_d.wp = step(st_q.wp);
            if (st_q.wp == AW'(DEPTH - 1)) begin
                st_d.full = 1'b1;
            end
            if (st_q.pend_trig) begin
                st_d.trig = 1'b1;
            end
            if (st_q.trig && st_q.cnt != 32'd0) begin
                st_d.cnt = st_q.cnt - 32'd1;
            end
            if (trig_now) begin
                finish = st_q.trig ? (st_q.cnt <= 32'd1) : (st_q.cnt == 32'd0);
            end
            if (finish) begin
                st_d.acq = 1'b1;
            end
        end

        if (restart) begin
            st_d.full = 1'b0;
            st_d.trig = 1'b0;
            st_d.acq  = 1'b0;
        end
        if (wp_ld) begin
            st_d.wp = ld_val[AW-1:0];
        end
        if (cnt_ld) begin
            st_d.cnt = ld_val;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ram_we     = store;
    assign ram_waddr  = st_q.wp;
    assign ram_wdata  = st_q.pend_word;
    assign wp         = st_q.wp;
    assign full       = st_q.full;
    assign triggered  = st_q.trig;
    assign acq_done   = st_q.acq;
    assign fmt_empty  = !st_q.pend;
    assign tcnt       = st_q.cnt;
    assign done_pulse = store && finish;

endmodule

// File: rtl/trb_regs.sv
module trb_regs
    import trb_pkg::*;
#(
    parameter int          DEPTH    = 16,
    parameter int          WIDTH    = 24,
    parameter logic [31:0] ID_VALUE = 32'h5452_4201,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [3:0]       cfg_addr,
    input  logic [31:0]      cfg_wdata,
    input  logic             cfg_wr,
    input  logic             cfg_rd,
    input  logic             done_pulse,
    input  logic             full,
    input  logic             triggered,
    input  logic             acq_done,
    input  logic             fmt_empty,
    input  logic [AW-1:0]    wp,
    input  logic [31:0]      tcnt,
    input  logic [WIDTH-1:0] ram_rdata,
    output logic [31:0]      cfg_rdata,
    output logic             cap_en,
    output logic             demux,
    output logic             restart,
    output logic             wp_ld,
    output logic             cnt_ld,
    output logic [AW-1:0]    rp
);

    typedef struct packed {
        logic          en;
        logic          demux;
        logic [AW-1:0] rp;
    } reg_state_t;

    reg_state_t rs_d, rs_q;

    function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    logic wr_ctrl;

    always_comb begin
        rs_d    = rs_q;
        wr_ctrl = cfg_wr && (cfg_addr == A_CTRL);
        restart = wr_ctrl && cfg_wdata[CT_EN] && !rs_q.en;
        wp_ld   = cfg_wr && (cfg_addr == A_WRPTR);
        cnt_ld  = cfg_wr && (cfg_addr == A_TCOUNT);

        if (wr_ctrl) begin
            rs_d.en    = cfg_wdata[CT_EN];
            rs_d.demux = cfg_wdata[CT_DEMUX];
        end
        if (done_pulse) begin
            rs_d.en = 1'b0;
        end
        if (cfg_rd && (cfg_addr == A_DATA)) begin
            rs_d.rp = step(rs_q.rp);
        end
        if (cfg_wr && (cfg_addr == A_RDPTR)) begin
            rs_d.rp = cfg_wdata[AW-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rs_q <= '0;
        end else begin
            rs_q <= rs_d;
        end
    end

    always_comb begin
        cfg_rdata = '0;
        case (reg_addr_e'(cfg_addr))
            A_IDENT:  cfg_rdata = ID_VALUE;
            A_DEPTH:  cfg_rdata = 32'(DEPTH);
            A_WIDTH:  cfg_rdata = 32'(WIDTH);
            A_STATUS: begin
                cfg_rdata[ST_FULL]  = full;
                cfg_rdata[ST_TRIG]  = triggered;
                cfg_rdata[ST_DONE]  = acq_done;
                cfg_rdata[ST_EMPTY] = fmt_empty;
            end
            A_DATA:   cfg_rdata[WIDTH-1:0] = ram_rdata;
            A_RDPTR:  cfg_rdata[AW-1:0] = rs_q.rp;
            A_WRPTR:  cfg_rdata[AW-1:0] = wp;
            A_TCOUNT: cfg_rdata = tcnt;
            A_CTRL: begin
                cfg_rdata[CT_EN]    = rs_q.en;
                cfg_rdata[CT_DEMUX] = rs_q.demux;
            end
            default:  cfg_rdata = '0;
        endcase
    end

    assign cap_en = rs_q.en;
    assign demux  = rs_q.demux;
    assign rp     = rs_q.rp;

endmodule

// File: rtl/trace_ring_buf.sv
module trace_ring_buf #(
    parameter int          DEPTH    = 16,
    parameter int          WIDTH    = 24,
    parameter logic [31:0] ID_VALUE = 32'h5452_4201
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             trc_valid,
    input  logic [WIDTH-1:0] trc_word,
    input  logic             trc_trig,
    input  logic [3:0]       cfg_addr,
    input  logic [31:0]      cfg_wdata,
    input  logic             cfg_wr,
    input  logic             cfg_rd,
    output logic [31:0]      cfg_rdata,
    output logic             demux_mode
);

    localparam int AW = $clog2(DEPTH);

    logic             cap_en;
    logic             restart;
    logic             wp_ld;
    logic             cnt_ld;
    logic             done_pulse;
    logic             ram_we;
    logic [AW-1:0]    ram_waddr;
    logic [WIDTH-1:0] ram_wdata;
    logic [WIDTH-1:0] ram_rdata;
    logic [AW-1:0]    wp;
    logic [AW-1:0]    rp;
    logic             full;
    logic             triggered;
    logic             acq_done;
    logic             fmt_empty;
    logic [31:0]      tcnt;

    trb_ring_ram #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_ram (
        .clk   (clk),
        .we    (ram_we),
        .waddr (ram_waddr),
        .wdata (ram_wdata),
        .raddr (rp),
        .rdata (ram_rdata)
    );

    trb_capture #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_cap (
        .clk        (clk),
        .rst_n      (rst_n),
        .cap_en     (cap_en),
        .restart    (restart),
        .in_valid   (trc_valid),
        .in_word    (trc_word),
        .in_trig    (trc_trig),
        .wp_ld      (wp_ld),
        .cnt_ld     (cnt_ld),
        .ld_val     (cfg_wdata),
        .ram_we     (ram_we),
        .ram_waddr  (ram_waddr),
        .ram_wdata  (ram_wdata),
        .wp         (wp),
        .full       (full),
        .triggered  (triggered),
        .acq_done   (acq_done),
        .fmt_empty  (fmt_empty),
        .tcnt       (tcnt),
        .done_pulse (done_pulse)
    );

    trb_regs #(.DEPTH(DEPTH), .WIDTH(WIDTH), .ID_VALUE(ID_VALUE)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_addr   (cfg_addr),
        .cfg_wdata  (cfg_wdata),
        .cfg_wr     (cfg_wr),
        .cfg_rd     (cfg_rd),
        .done_pulse (done_pulse),
        .full       (full),
        .triggered  (triggered),
        .acq_done   (acq_done),
        .fmt_empty  (fmt_empty),
        .wp         (wp),
        .tcnt       (tcnt),
        .ram_rdata  (ram_rdata),
        .cfg_rdata  (cfg_rdata),
        .cap_en     (cap_en),
        .demux      (demux_mode),
        .restart    (restart),
        .wp_ld      (wp_ld),
        .cnt_ld     (cnt_ld),
        .rp         (rp)
    );

endmodule

// File: rtl/trb_checker.sv
module trb_checker
    import trb_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int AW = $clog2(DEPTH)
) (
    input logic          clk,
    input logic          rst_n,
    input logic [3:0]    cfg_addr,
    input logic [31:0]   cfg_wdata,
    input logic          cfg_wr,
    input logic          cfg_rd,
    input logic          trc_valid,
    input logic          demux_mode,
    input logic          cap_en,
    input logic          restart,
    input logic          wp_ld,
    input logic [AW-1:0] wp,
    input logic [AW-1:0] rp,
    input logic          full,
    input logic          acq_done,
    input logic          fmt_empty
);

    function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    // R4
    full_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !restart) |=> full);

    // R3
    wp_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wp_ld |=> (wp == $past(wp) || wp == step($past(wp))));

    // R5
    done_stops_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acq_done |-> !cap_en);

    // R11
    fmt_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trc_valid && cap_en) |=> !fmt_empty);

    // R7
    rp_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rd && cfg_addr == A_DATA && !cfg_wr) |=> rp == step($past(rp)));

    // R10
    demux_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && cfg_addr == A_CTRL) |=> demux_mode == $past(cfg_wdata[CT_DEMUX]));

endmodule

bind trace_ring_buf trb_checker #(.DEPTH(DEPTH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_addr   (cfg_addr),
    .cfg_wdata  (cfg_wdata),
    .cfg_wr     (cfg_wr),
    .cfg_rd     (cfg_rd),
    .trc_valid  (trc_valid),
    .demux_mode (demux_mode),
    .cap_en     (cap_en),
    .restart    (restart),
    .wp_ld      (wp_ld),
    .wp         (wp),
    .rp         (rp),
    .full       (full),
    .acq_done   (acq_done),
    .fmt_empty  (fmt_empty)
);

// File: tb/trace_ring_buf_bench.sv
`timescale 1ns/1ps
module trace_ring_buf_bench;
    import trb_pkg::*;

    localparam int DEPTH = 16;
    localparam int WIDTH = 24;
    localparam logic [31:0] IDV = 32'h5452_4201;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic trc_valid = 1'b0;
    logic [WIDTH-1:0] trc_word = '0;
    logic trc_trig = 1'b0;
    logic [3:0] cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic cfg_wr = 1'b0;
    logic cfg_rd = 1'b0;
    logic [31:0] cfg_rdata;
    logic demux_mode;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    trace_ring_buf #(.DEPTH(DEPTH), .WIDTH(WIDTH), .ID_VALUE(IDV)) u_trace_ring_buf (
        .clk        (clk),
        .rst_n      (rst_n),
        .trc_valid  (trc_valid),
        .trc_word   (trc_word),
        .trc_trig   (trc_trig),
        .cfg_addr   (cfg_addr),
        .cfg_wdata  (cfg_wdata),
        .cfg_wr     (cfg_wr),
        .cfg_rd     (cfg_rd),
        .cfg_rdata  (cfg_rdata),
        .demux_mode (demux_mode)
    );

    function automatic logic [31:0] wf(input int i);
        return (32'h00A5_0000 + 32'(i) * 32'h0000_0111) & 32'h00FF_FFFF;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wr(input reg_addr_e a, input logic [31:0] d);
        @(negedge clk);
        cfg_addr = a; cfg_wdata = d; cfg_wr = 1'b1;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic expect_reg(input string req, input reg_addr_e a, input logic [31:0] exp);
        logic [31:0] v;
        @(negedge clk);
        cfg_addr = a; cfg_rd = 1'b1;
        #1 v = cfg_rdata;
        @(negedge clk);
        cfg_rd = 1'b0;
        check(req, v, exp);
    endtask

    // offer words first..first+n-1 back to back; trigger mark on index tix
    task automatic push_n(input int first, input int n, input int tix);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            trc_valid = 1'b1;
            trc_word  = wf(first + i)[WIDTH-1:0];
            trc_trig  = (i == tix);
        end
        @(negedge clk);
        trc_valid = 1'b0; trc_trig = 1'b0;
        idle(2);
    endtask

    task automatic t_reset;
        expect_reg("R1 ctrl", A_CTRL, 32'h0);
        expect_reg("R1 status", A_STATUS, 32'h8);
        expect_reg("R1 wp", A_WRPTR, 32'h0);
        expect_reg("R1 rp", A_RDPTR, 32'h0);
        expect_reg("R1 tcount", A_TCOUNT, 32'h0);
        wr(A_IDENT, 32'hDEAD_BEEF);
        wr(A_DEPTH, 32'h3);
        wr(A_WIDTH, 32'h7);
        expect_reg("R2 ident", A_IDENT, IDV);
        expect_reg("R2 depth", A_DEPTH, 32'(DEPTH));
        expect_reg("R2 width", A_WIDTH, 32'(WIDTH));
        wr(A_WRPTR, 32'd5);
        expect_reg("R3 wp load", A_WRPTR, 32'd5);
        wr(A_WRPTR, 32'd0);
    endtask

    task automatic t_basic;
        logic [31:0] v;
        wr(A_TCOUNT, 32'd100);
        wr(A_CTRL, 32'h1);
        @(negedge clk);
        cfg_addr = A_STATUS;
        trc_valid = 1'b1; trc_word = wf(0)[WIDTH-1:0];
        @(negedge clk);
        trc_valid = 1'b0;
        #1 v = cfg_rdata;
        check("R11 pending", {28'h0, v[3:0]} & 32'h8, 32'h0);
        @(negedge clk);
        #1 v = cfg_rdata;
        check("R11 drained", v & 32'h8, 32'h8);
        push_n(1, 4, -1);
        expect_reg("R3 wp after 5", A_WRPTR, 32'd5);
        wr(A_RDPTR, 32'd0);
        for (int i = 0; i < 5; i++) expect_reg("R7 data", A_DATA, wf(i));
        expect_reg("R7 rp after reads", A_RDPTR, 32'd5);
    endtask

    task automatic t_wrap;
        wr(A_CTRL, 32'h0);
        wr(A_WRPTR, 32'h0);
        wr(A_CTRL, 32'h1);
        push_n(100, DEPTH, -1);
        expect_reg("R4 wp wrapped", A_WRPTR, 32'd0);
        expect_reg("R4 full set", A_STATUS, 32'h9);
        push_n(100 + DEPTH, 2, -1);
        expect_reg("R4 wp", A_WRPTR, 32'd2);
        expect_reg("R4 full sticky", A_STATUS, 32'h9);
        wr(A_RDPTR, 32'(DEPTH - 2));
        expect_reg("R7 slot d-2", A_DATA, wf(100 + DEPTH - 2));
        expect_reg("R7 slot d-1", A_DATA, wf(100 + DEPTH - 1));
        expect_reg("R7 slot 0", A_DATA, wf(100 + DEPTH));
        expect_reg("R7 rp wrap", A_RDPTR, 32'd1);
    endtask

    task automatic t_trigger;
        wr(A_CTRL, 32'h0);
        wr(A_WRPTR, 32'h0);
        wr(A_TCOUNT, 32'd3);
        wr(A_CTRL, 32'h1);
        expect_reg("R9 flags cleared", A_STATUS, 32'h8);
        push_n(200, 8, 2);
        expect_reg("R5 wp", A_WRPTR, 32'd6);
        expect_reg("R5 status", A_STATUS, 32'hE);
        expect_reg("R5 ctrl off", A_CTRL, 32'h0);
        expect_reg("R5 tcount", A_TCOUNT, 32'h0);
        wr(A_RDPTR, 32'd2);
        for (int i = 2; i < 6; i++) expect_reg("R5 window", A_DATA, wf(200 + i));
        expect_reg("R5 no late store", A_DATA, wf(106));
    endtask

    task automatic t_zero_count;
        wr(A_WRPTR, 32'h0);
        wr(A_TCOUNT, 32'd0);
        wr(A_CTRL, 32'h1);
        push_n(300, 4, 1);
        expect_reg("R6 wp", A_WRPTR, 32'd2);
        expect_reg("R6 status", A_STATUS, 32'hE);
    endtask

    task automatic t_stop;
        wr(A_WRPTR, 32'h0);
        wr(A_TCOUNT, 32'd100);
        wr(A_CTRL, 32'h1);
        push_n(400, 2, -1);
        expect_reg("R8 wp running", A_WRPTR, 32'd2);
        wr(A_CTRL, 32'h0);
        push_n(402, 3, -1);
        expect_reg("R8 wp held", A_WRPTR, 32'd2);
        expect_reg("R8 status", A_STATUS, 32'h8);
        wr(A_RDPTR, 32'd2);
        expect_reg("R8 slot untouched", A_DATA, wf(202));
    endtask

    task automatic t_demux;
        wr(A_CTRL, 32'h2);
        check("R10 demux on", 32'(demux_mode), 32'h1);
        expect_reg("R10 ctrl read", A_CTRL, 32'h2);
        wr(A_CTRL, 32'h0);
        check("R10 demux off", 32'(demux_mode), 32'h0);
    endtask

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(2);
        t_reset;
        t_basic;
        t_wrap;
        t_trigger;
        t_zero_count;
        t_stop;
        t_demux;
        if (!finished) begin
            finished = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #(200000 * 5);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule